// File: doc/BRIEF.md
# Short Literal Operand Expander

This block turns a 6-bit short literal, taken from an instruction's operand specifier, into a full 32-bit operand of the type the instruction needs. It has two paths. For integer operands it zero-extends the literal, which gives an unsigned value from 0 to 63. For floating operands it reads the literal as a tiny hidden-bit number and produces a normalised single-precision word.

The floating form packs a 3-bit exponent in the upper half of the literal and a 3-bit fraction in the lower half. The significand is always binary .1fff, so the value is (8 + f) / 16 scaled by 2^e, with e from 0 to 7. The result is always positive and never zero. No rounding and no special values can arise.

A valid strobe goes with each literal. The expanded word is registered and appears one clock later with its own strobe. Between strobes the output word holds its last value.

Top module: `slx_literal_expander`

## Requirements
- R1: During and directly after reset, `out_vld_o` is 0 and `out_data_o` is all zeros.
- R2: `out_vld_o` is 1 in exactly the cycle after a cycle in which `in_vld_i` was 1, and is 0 otherwise.
- R3: With `kind_i` = 0 (integer), the registered word equals the literal zero-extended to 32 bits, giving values 0 to 63.
- R4: With `kind_i` = 1 (floating), bit 31 (sign) of the registered word is 0.
- R5: With `kind_i` = 1, bits 30:23 (biased exponent) equal `lit_i[5:3]` + 126.
- R6: With `kind_i` = 1, bits 22:20 equal `lit_i[2:0]` and bits 19:0 are zero.
- R7: Fixed floating points: literal 6'b000100 gives 0.75 (32'h3F400000), literal 0 gives 0.5 (32'h3F000000), and literal 63 gives 120.0 (32'h42F00000).
- R8: In a cycle with `in_vld_i` = 0, changes on `lit_i` and `kind_i` leave `out_data_o` unchanged on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lit_i | input | 6 | Short literal: exponent in [5:3], fraction in [2:0] |
| kind_i | input | 1 | Operand type: 0 integer, 1 single-precision float |
| in_vld_i | input | 1 | Literal valid strobe |
| out_data_o | output | 32 | Expanded operand, registered |
| out_vld_o | output | 1 | Output valid, one cycle after `in_vld_i` |

## Verification
The bench builds the block with its default split of 3 exponent bits and 3 fraction bits into a 32-bit word. That keeps the input space at 64 literals times 2 kinds, so every combination is applied and checked. Expected float words come from normalising the integer (8 + f) << e in the bench, not from a bias formula. Runs of strobes, gaps with changing idle inputs, and the three anchor literals are also covered.

// File: rtl/slx_pkg.sv
package slx_pkg;
  typedef enum logic {
    KIND_INT = 1'b0,
    KIND_FLT = 1'b1
  } lit_kind_e;
endpackage

// File: rtl/slx_int_path.sv
module slx_int_path #(
  parameter int LIT_W = 6,
  parameter int OUT_W = 32
) (
  input  logic [LIT_W-1:0] lit,
  output logic [OUT_W-1:0] word
);
  localparam int PAD_W = OUT_W - LIT_W;

  function automatic logic [OUT_W-1:0] zext(input logic [LIT_W-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  generate
    if (PAD_W > 0) begin : g_pad
      assign word = zext(lit);
    end else begin : g_trunc
      assign word = lit[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/slx_flt_path.sv
module slx_flt_path #(
  parameter int EXP_W      = 3,
  parameter int FRAC_W     = 3,
  parameter int OUT_W      = 32,
  parameter int FP_EXP_W   = 8,
  parameter int FP_BIAS    = 127
) (
  input  logic [EXP_W+FRAC_W-1:0] lit,
  output logic [OUT_W-1:0]        word
);
  localparam int LIT_W     = EXP_W + FRAC_W;
  localparam int FP_FRAC_W = OUT_W - 1 - FP_EXP_W;
  localparam int TAIL_W    = FP_FRAC_W - FRAC_W;
  // significand .1fff is 1.fff x 2^-1, so one is taken off the bias
  localparam int EXP_OFS   = FP_BIAS - 1;

  function automatic logic [FP_EXP_W-1:0] bexp(input logic [EXP_W-1:0] e);
    return {{(FP_EXP_W-EXP_W){1'b0}}, e} + FP_EXP_W'(EXP_OFS);
  endfunction

  function automatic logic [FP_FRAC_W-1:0] bfrac(input logic [FRAC_W-1:0] f);
    return {f, {TAIL_W{1'b0}}};
  endfunction

  logic [EXP_W-1:0]  e_fld;
  logic [FRAC_W-1:0] f_fld;

  assign e_fld = lit[LIT_W-1:FRAC_W];
  assign f_fld = lit[FRAC_W-1:0];
  assign word  = {1'b0, bexp(e_fld), bfrac(f_fld)};
endmodule

// File: rtl/slx_literal_expander.sv
module slx_literal_expander #(
  parameter int EXP_W    = 3,
  parameter int FRAC_W   = 3,
  parameter int OUT_W    = 32,
  parameter int FP_EXP_W = 8,
  parameter int FP_BIAS  = 127
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [EXP_W+FRAC_W-1:0]   lit_i,
  input  logic                      kind_i,
  input  logic                      in_vld_i,
  output logic [OUT_W-1:0]          out_data_o,
  output logic                      out_vld_o
);
  import slx_pkg::*;

  localparam int LIT_W     = EXP_W + FRAC_W;
  localparam int FP_FRAC_W = OUT_W - 1 - FP_EXP_W;

  lit_kind_e        kind;
  logic [OUT_W-1:0] int_word;
  logic [OUT_W-1:0] flt_word;
  logic [OUT_W-1:0] sel_word;
  logic             load_evt;

  assign kind     = lit_kind_e'(kind_i);
  assign load_evt = in_vld_i;

  slx_int_path #(.LIT_W(LIT_W), .OUT_W(OUT_W)) u_int (
    .lit  (lit_i),
    .word (int_word)
  );

  slx_flt_path #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W),
    .FP_EXP_W(FP_EXP_W), .FP_BIAS(FP_BIAS)
  ) u_flt (
    .lit  (lit_i),
    .word (flt_word)
  );

  always_comb begin
    case (kind)
      KIND_FLT: sel_word = flt_word;
      default:  sel_word = int_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data_o <= '0;
      out_vld_o  <= 1'b0;
    end else begin
      out_vld_o <= load_evt;
      if (load_evt) out_data_o <= sel_word;
    end
  end

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!out_vld_o && out_data_o == '0));

  // R2: valid is the input strobe delayed one cycle
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld_i |=> out_vld_o);
  a_r2_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld_i |=> !out_vld_o);

  // R3: integer operand is the literal with zero upper bits
  a_r3_int_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld_i && !kind_i) |=>
      (out_data_o[LIT_W-1:0] == $past(lit_i) && out_data_o[OUT_W-1:LIT_W] == '0));

  // R4: float literal is never negative
  a_r4_sign_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld_i && kind_i) |=> !out_data_o[OUT_W-1]);

  // R6: low fraction bits below the stored three are zero
  a_r6_frac_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld_i && kind_i) |=>
      (out_data_o[FP_FRAC_W-1 -: FRAC_W] == $past(lit_i[FRAC_W-1:0]) &&
       out_data_o[FP_FRAC_W-FRAC_W-1:0] == '0));

  // R5: exponent of the smallest literal matches the offset bias
  a_r5_exp_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld_i && kind_i && lit_i[LIT_W-1:FRAC_W] == '0) |=>
      out_data_o[OUT_W-2 -: FP_EXP_W] == FP_EXP_W'(FP_BIAS - 1));

  // R8: output word holds while no strobe
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld_i |=> $stable(out_data_o));
endmodule

// File: tb/tb_slx_literal_expander.sv
module tb_slx_literal_expander;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  lit_i;
  logic        kind_i;
  logic        in_vld_i;
  logic [31:0] out_data_o;
  logic        out_vld_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  slx_literal_expander dut (
    .clk(clk), .rst_n(rst_n), .lit_i(lit_i), .kind_i(kind_i),
    .in_vld_i(in_vld_i), .out_data_o(out_data_o), .out_vld_o(out_vld_o)
  );

  function automatic logic [31:0] ref_float(input logic [5:0] l);
    int m, p;
    logic [31:0] shifted;
    m = (8 + int'(l[2:0])) << int'(l[5:3]);
    p = 0;
    for (int i = 0; i < 16; i++) if (m[i]) p = i;
    shifted = 32'(m) << (23 - p);
    // value = m / 16 = 1.x * 2^(p-4)
    return {1'b0, 8'(p - 4 + 127), shifted[22:0]};
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] l, input logic k);
    @(negedge clk);
    lit_i = l; kind_i = k; in_vld_i = 1'b1;
    @(negedge clk);
    in_vld_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; lit_i = '0; kind_i = 1'b0; in_vld_i = 1'b0;
    repeat (3) @(negedge clk);
    check32("R1 vld", {31'b0, out_vld_o}, 32'd0);
    check32("R1 data", out_data_o, 32'd0);
    rst_n = 1'b1;

    // R3: all integer literals
    for (int v = 0; v < 64; v++) begin
      apply(6'(v), 1'b0);
      check32("R2", {31'b0, out_vld_o}, 32'd1);
      check32("R3", out_data_o, 32'(v));
    end

    // R4 R5 R6: all float literals vs normalised reference
    for (int v = 0; v < 64; v++) begin
      apply(6'(v), 1'b1);
      check32("R4/R5/R6", out_data_o, ref_float(6'(v)));
      check32("R5 exp", {24'b0, out_data_o[30:23]}, 32'(v / 8 + 126));
    end

    // R7 anchors
    apply(6'b000100, 1'b1); check32("R7 0.75", out_data_o, 32'h3F400000);
    apply(6'd0, 1'b1);      check32("R7 0.5", out_data_o, 32'h3F000000);
    apply(6'd63, 1'b1);     check32("R7 120.0", out_data_o, 32'h42F00000);

    // R8: idle with changing inputs
    @(negedge clk);
    check32("R2 idle", {31'b0, out_vld_o}, 32'd0);
    lit_i = 6'd5; kind_i = 1'b0;
    @(negedge clk);
    check32("R8", out_data_o, 32'h42F00000);
    check32("R2 idle", {31'b0, out_vld_o}, 32'd0);
    lit_i = 6'd17; kind_i = 1'b1;
    @(negedge clk);
    check32("R8", out_data_o, 32'h42F00000);

    // R2: back-to-back strobes, mixed kinds
    in_vld_i = 1'b1; lit_i = 6'd9; kind_i = 1'b0;
    @(negedge clk);
    check32("R3 burst", out_data_o, 32'd9);
    lit_i = 6'd9; kind_i = 1'b1;
    @(negedge clk);
    check32("R6 burst", out_data_o, ref_float(6'd9));
    check32("R2 burst", {31'b0, out_vld_o}, 32'd1);
    in_vld_i = 1'b0;
    @(negedge clk);
    check32("R2 end", {31'b0, out_vld_o}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule